// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Controller

This block drives the speed-control line of a 3-pin or 4-pin fan header. It reads two alarm flags from an on-chip temperature monitor. The user-temperature alarm asserts at 35 °C and releases at 30 °C. The over-temperature alarm asserts at 80 °C and releases at 60 °C. Both flags arrive with their hysteresis already applied. The block turns these flags into one of three fan speeds and produces a slow PWM waveform.

After reset the fan runs at full speed for a startup window of half a second. After that window the speed follows the alarms:
- With no alarm, the speed is low.
- With only the user alarm, the speed is medium.
- With the over-temperature alarm, the speed is full. This applies whether or not the user alarm is also set.

Each duty setting is a 4-bit step count out of 15. The PWM carrier runs at 10 Hz, derived from the clock-frequency parameter. Two-flop synchronizers can be placed on the asynchronous inputs. An optional tachometer counts rising edges of the fan tach line over a one-second gate. At the end of each gate it publishes the count, saturating at the output's full scale. The block has no streaming data path, so every pin is a plain level signal.

Top module: `fanctl_top`

## Requirements
- R1: While `rst` is high, `fan_pwm_o` is 0 and `tach_freq_o` is 0, whatever the alarm and tach inputs do.
- R2: For the first CLK_HZ/STARTUP_HZ cycles after reset, `fan_pwm_o` stays high continuously, whatever the alarm inputs are.
- R3: After startup, with both alarms low, the output is high for DUTY_LOW (default 4) of every 15 PWM slots.
- R4: After startup, with only `alarm_user_i` high, the output is high for DUTY_MID (default 9) of every 15 slots.
- R5: After startup, whenever `alarm_over_i` is high, the output is high in every slot (DUTY_HIGH, default 15). This holds whatever `alarm_user_i` is.
- R6: One PWM period is 15 slots of CLK_HZ/(PWM_HZ*15) cycles each. Within a period the high slots are contiguous, so the longest high run is duty × slot cycles.
- R7: With TACH_EN set, `tach_freq_o` holds the number of rising edges seen on `tach_i` during the last completed gate of CLK_HZ/GATE_HZ cycles. The value changes only at a gate end.
- R8: The tachometer count saturates at 2^TACH_W-1 instead of wrapping.
- R9: With TACH_EN clear, `tach_freq_o` stays 0 regardless of `tach_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_user_i | input | 1 | User-temperature alarm, hysteretic, may be asynchronous |
| alarm_over_i | input | 1 | Over-temperature alarm, hysteretic, may be asynchronous |
| tach_i | input | 1 | Fan tachometer pulse line |
| fan_pwm_o | output | 1 | PWM drive to the fan header |
| tach_freq_o | output | TACH_W | Tach edges counted per gate |

## Verification
The bench sets CLK_HZ to 1500. This gives 10-cycle PWM slots, a 150-cycle carrier, a 750-cycle startup window and a 1500-cycle tach gate, so every timing window fits into a short run.

It builds three instances:
- The main instance has synchronizers and the tachometer enabled.
- A second instance has synchronizers and the tachometer disabled. It checks the bypass variant and the zero output.
- A third instance has a 4-bit tach output. It brings saturation within reach of a few dozen pulses.

// File: rtl/fanctl_pkg.sv
package fanctl_pkg;
  typedef enum logic [1:0] {
    SPEED_LOW  = 2'd0,
    SPEED_MID  = 2'd1,
    SPEED_FULL = 2'd2
  } fan_speed_e;

  function automatic fan_speed_e pick_speed(input logic user_hot, input logic over_hot);
    if (over_hot)      return SPEED_FULL;
    else if (user_hot) return SPEED_MID;
    else               return SPEED_LOW;
  endfunction
endpackage

// File: rtl/fanctl_sync.sv
module fanctl_sync #(
  parameter bit EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (EN) begin : g_sync
      logic [1:0] stage_q;
      always_ff @(posedge clk) begin
        if (rst) stage_q <= 2'b00;
        else     stage_q <= {stage_q[0], d_i};
      end
      assign q_o = stage_q[1];
    end else begin : g_bypass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/fanctl_startup.sv
module fanctl_startup #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int STARTUP_HZ = 2
) (
  input  logic clk,
  input  logic rst,
  output logic active_o
);
  localparam int CYC = (CLK_HZ / STARTUP_HZ < 1) ? 1 : CLK_HZ / STARTUP_HZ;
  localparam int CW  = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(CYC - 1)) done_q <= 1'b1;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign active_o = !done_q;
endmodule

// File: rtl/fanctl_pwm.sv
module fanctl_pwm #(
  parameter int CLK_HZ = 100_000_000,
  parameter int PWM_HZ = 10,
  parameter int DUTY_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int STEPS    = (1 << DUTY_W) - 1;
  localparam int RAW_DIV  = CLK_HZ / (PWM_HZ * STEPS);
  localparam int SLOT_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int PW       = $clog2(SLOT_DIV + 1);

  logic [PW-1:0]     pre_q;
  logic [DUTY_W-1:0] slot_q;
  logic              slot_end;

  assign slot_end = (pre_q == PW'(SLOT_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      slot_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      pre_q <= slot_end ? '0 : pre_q + 1'b1;
      if (slot_end)
        slot_q <= (slot_q == DUTY_W'(STEPS - 1)) ? '0 : slot_q + 1'b1;
      pwm_o <= (slot_q < duty_i);
    end
  end
endmodule

// File: rtl/fanctl_tacho.sv
module fanctl_tacho #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int GATE_HZ = 1,
  parameter int TACH_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tach_s_i,
  output logic              gate_end_o,
  output logic [TACH_W-1:0] freq_o
);
  localparam int GATE_CYC = (CLK_HZ / GATE_HZ < 1) ? 1 : CLK_HZ / GATE_HZ;
  localparam int GW       = $clog2(GATE_CYC + 1);

  logic [GW-1:0]     gate_q;
  logic [TACH_W-1:0] edges_q;
  logic              prev_q;
  logic              rise;

  assign rise       = tach_s_i && !prev_q;
  assign gate_end_o = (gate_q == GW'(GATE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      edges_q <= '0;
      prev_q  <= 1'b0;
      freq_o  <= '0;
    end else begin
      prev_q <= tach_s_i;
      if (gate_end_o) begin
        gate_q  <= '0;
        freq_o  <= edges_q;
        edges_q <= '0;
      end else begin
        gate_q <= gate_q + 1'b1;
        if (rise && (edges_q != {TACH_W{1'b1}}))
          edges_q <= edges_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fanctl_top.sv
module fanctl_top #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int PWM_HZ     = 10,
  parameter int STARTUP_HZ = 2,
  parameter int GATE_HZ    = 1,
  parameter int DUTY_W     = 4,
  parameter int DUTY_LOW   = 4,
  parameter int DUTY_MID   = 9,
  parameter int DUTY_HIGH  = 15,
  parameter int TACH_W     = 16,
  parameter bit SYNC_EN    = 1'b1,
  parameter bit TACH_EN    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_user_i,
  input  logic              alarm_over_i,
  input  logic              tach_i,
  output logic              fan_pwm_o,
  output logic [TACH_W-1:0] tach_freq_o
);
  import fanctl_pkg::*;

  logic              user_s;
  logic              over_s;
  logic              startup_active;
  logic              gate_end;
  logic [DUTY_W-1:0] duty;
  fan_speed_e        speed;

  fanctl_sync #(.EN(SYNC_EN)) sync_user_i (
    .clk(clk), .rst(rst), .d_i(alarm_user_i), .q_o(user_s));
  fanctl_sync #(.EN(SYNC_EN)) sync_over_i (
    .clk(clk), .rst(rst), .d_i(alarm_over_i), .q_o(over_s));

  fanctl_startup #(.CLK_HZ(CLK_HZ), .STARTUP_HZ(STARTUP_HZ)) startup_i (
    .clk(clk), .rst(rst), .active_o(startup_active));

  always_comb begin
    speed = pick_speed(user_s, over_s);
    if (startup_active) duty = DUTY_W'(DUTY_HIGH);
    else begin
      case (speed)
        SPEED_FULL: duty = DUTY_W'(DUTY_HIGH);
        SPEED_MID:  duty = DUTY_W'(DUTY_MID);
        default:    duty = DUTY_W'(DUTY_LOW);
      endcase
    end
  end

  fanctl_pwm #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .DUTY_W(DUTY_W)) pwm_i (
    .clk(clk), .rst(rst), .duty_i(duty), .pwm_o(fan_pwm_o));

  generate
    if (TACH_EN) begin : g_tach
      logic tach_s;
      fanctl_sync #(.EN(SYNC_EN)) sync_tach_i (
        .clk(clk), .rst(rst), .d_i(tach_i), .q_o(tach_s));
      fanctl_tacho #(.CLK_HZ(CLK_HZ), .GATE_HZ(GATE_HZ), .TACH_W(TACH_W)) tacho_i (
        .clk(clk), .rst(rst), .tach_s_i(tach_s),
        .gate_end_o(gate_end), .freq_o(tach_freq_o));
    end else begin : g_no_tach
      logic unused_tach;
      assign unused_tach = tach_i;
      assign gate_end    = 1'b0;
      assign tach_freq_o = '0;
    end
  endgenerate
endmodule

// File: rtl/fanctl_checker.sv
module fanctl_checker #(
  parameter int TACH_W  = 16,
  parameter bit TACH_EN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              startup_active,
  input logic              over_s,
  input logic              gate_end,
  input logic              pwm,
  input logic [TACH_W-1:0] tach
);
  AST_STARTUP_FULL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(startup_active)) |-> pwm); // R2

  AST_OVER_FULL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(over_s)) |-> pwm); // R5

  AST_TACH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_end) |-> $stable(tach)); // R7

  AST_TACH_OFF: assert property (@(posedge clk) disable iff (rst)
    !TACH_EN |-> (tach == '0)); // R9
endmodule

bind fanctl_top fanctl_checker #(.TACH_W(TACH_W), .TACH_EN(TACH_EN)) chk_i (
  .clk(clk), .rst(rst), .startup_active(startup_active), .over_s(over_s),
  .gate_end(gate_end), .pwm(fan_pwm_o), .tach(tach_freq_o));

// File: tb/fanctl_top_tb_top.sv
module fanctl_top_tb_top;
  localparam int CLK_HZ   = 1500;
  localparam int SLOT     = 10;
  localparam int PERIOD   = 150;
  localparam int STARTUP  = 750;
  localparam int GATE     = 1500;
  localparam int D_LOW    = 4;
  localparam int D_MID    = 9;
  localparam int D_HIGH   = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic user = 1'b0, over = 1'b0, tach = 1'b0;
  logic        pwm_a, pwm_b, pwm_c;
  logic [15:0] freq_a, freq_b;
  logic [3:0]  freq_c;
  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  fanctl_top #(.CLK_HZ(CLK_HZ), .TACH_EN(1'b1), .SYNC_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .alarm_user_i(user), .alarm_over_i(over), .tach_i(tach),
    .fan_pwm_o(pwm_a), .tach_freq_o(freq_a));
  fanctl_top #(.CLK_HZ(CLK_HZ), .TACH_EN(1'b0), .SYNC_EN(1'b0)) dut_nt (
    .clk(clk), .rst(rst), .alarm_user_i(user), .alarm_over_i(over), .tach_i(tach),
    .fan_pwm_o(pwm_b), .tach_freq_o(freq_b));
  fanctl_top #(.CLK_HZ(CLK_HZ), .TACH_EN(1'b1), .TACH_W(4)) dut_sat (
    .clk(clk), .rst(rst), .alarm_user_i(user), .alarm_over_i(over), .tach_i(tach),
    .fan_pwm_o(pwm_c), .tach_freq_o(freq_c));

  function automatic int exp_duty(input logic u, input logic o);
    if (o) return D_HIGH;
    if (u) return D_MID;
    return D_LOW;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic measure(input int len, output int hi_a, output int run_a, output int hi_b);
    int run;
    hi_a = 0; run_a = 0; hi_b = 0; run = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_a) begin hi_a++; run++; if (run > run_a) run_a = run; end
      else run = 0;
      if (pwm_b) hi_b++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tach = 1'b1; repeat (3) @(negedge clk);
      tach = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int hi, run, hib, d, n;
    logic u, o;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: outputs held low in reset despite active inputs
    over = 1'b1; user = 1'b1; tach = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 pwm in reset", int'(pwm_a), 0);
    check("R1 tach in reset", int'(freq_a), 0);
    over = 1'b0; tach = 1'b0;
    rst = 1'b0;
    // R2: full speed through startup with alarms changing
    hi = 0;
    for (int i = 0; i < STARTUP - 10; i++) begin
      @(negedge clk);
      if (i == 100) user = 1'b0;
      if (i == 300) user = 1'b1;
      if (i == 500) user = 1'b0;
      if (i >= 3 && pwm_a && pwm_b) hi++;
    end
    check("R2 startup high", hi, STARTUP - 13);
    wait_cyc(STARTUP + 20);
    // R3 / R6 directed: no alarm
    measure(2 * PERIOD, hi, run, hib);
    check("R3 low duty", hi, 2 * D_LOW * SLOT);
    check("R3 low duty no-sync", hib, 2 * D_LOW * SLOT);
    check("R6 high run low", run, D_LOW * SLOT);
    // R4 directed
    user = 1'b1; repeat (10) @(negedge clk);
    measure(2 * PERIOD, hi, run, hib);
    check("R4 mid duty", hi, 2 * D_MID * SLOT);
    check("R6 high run mid", run, D_MID * SLOT);
    // R5 directed: over alone, then both
    user = 1'b0; over = 1'b1; repeat (10) @(negedge clk);
    measure(2 * PERIOD, hi, run, hib);
    check("R5 over alone", hi, 2 * PERIOD);
    user = 1'b1; repeat (10) @(negedge clk);
    measure(2 * PERIOD, hi, run, hib);
    check("R5 both alarms", hi, 2 * PERIOD);
    check("R5 both no-sync", hib, 2 * PERIOD);
    // random alarm states (R3 R4 R5)
    for (int k = 0; k < 8; k++) begin
      u = 1'($urandom()); o = 1'($urandom());
      user = u; over = o;
      repeat (10) @(negedge clk);
      d = exp_duty(u, o);
      measure(PERIOD, hi, run, hib);
      check(o ? "R5 random" : (u ? "R4 random" : "R3 random"), hi, d * SLOT);
      check("R3/R4/R5 random no-sync", hib, d * SLOT);
    end
    user = 1'b0; over = 1'b0;
    // R7 / R8 / R9 tachometer
    do_reset();
    for (int g = 0; g < 3; g++) begin
      n = (g == 0) ? 20 : int'($urandom_range(150, 1));
      wait_cyc(g * GATE + 100);
      pulses(n);
      wait_cyc((g + 1) * GATE + 50);
      check("R7 tach count", int'(freq_a), n);
      check("R8 tach saturate", int'(freq_c), (n > 15) ? 15 : n);
      check("R9 tach disabled", int'(freq_b), 0);
      wait_cyc((g + 1) * GATE + 60);
    end
    // R7: value held within a gate with no new pulses
    wait_cyc(3 * GATE + 700);
    check("R7 hold mid-gate", int'(freq_a), n);
    wait_cyc(4 * GATE + 50);
    check("R7 empty gate", int'(freq_a), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule